// File: doc/BRIEF.md
# Isolated Memory Region Access Filter

This block sits in front of a memory port and decides, one transaction at a time, whether a requesting agent may touch a given physical address. It holds eight programmable regions at a granularity of 1 KiB. Each region carries a separate permission mask for reads and for writes, and each mask has one bit per agent. Regions may overlap. Every enabled region that covers the address is checked in parallel, and the transaction passes only if none of them refuses it.

When a transaction is refused, a write is kept away from memory and a read returns all-ones data in place of memory data. A sticky reset request is also raised toward the system. A word-addressed register port programs the regions. Each region has a lock that freezes its four registers until the next reset. Transactions enter through a valid/ready handshake. The decision appears on a one-entry output stage on the clock after acceptance, and that stage also drives the memory strobes.

Top module: `memguard_filter`

## Requirements
- R1: After reset, every region reads back low=0x00000000, high=0x00000000, read mask=0xBFFFFFFF and write mask=0xFFFFFFFF, and is unlocked. `rst_req` and `dec_valid` are low and `txn_ready` is high. Every transaction is allowed.
- R2: Region n occupies word addresses 0x40+4n through 0x43+4n, in the order low, high, read mask, write mask. In the low and high registers, bits 23:2 hold physical address bits 31:10. Bit 31 of the low register is the lock. Every other bit of the address registers reads 0. Word addresses outside 0x40..0x5F read 0, and writes to them change nothing.
- R3: A region covers a physical address when address bits 31:10 lie between the low and high fields, inclusive at both ends. The last covered byte is therefore high×1024+0x3FF, and the block just past that byte is not covered.
- R4: A region is disabled exactly when both address fields are zero, the read mask is 0xBFFFFFFF and the write mask is 0xFFFFFFFF. Any other contents enable it, so zero addresses with a restricted mask still guard bytes 0x000–0x3FF.
- R5: A write is checked against the write mask and a read against the read mask. A transaction is refused when any bit set in `txn_agent` is clear in that mask of a covering enabled region. Agent bits: 0 processor normal mode, 1 processor system-management mode, 11:8 channel-0 requesters 3..0, 15:12 channel-1 requesters 3..0, 29 maintenance unit, 30 snoop writeback, 31 scratchpad flush.
- R6: Bit 30 of each read mask is hardwired to 0, because the snoop agent only writes. A read carrying agent bit 30 is never refused on account of that bit.
- R7: With overlapping regions, a transaction is allowed only if no covering enabled region refuses it.
- R8: An allowed write raises `mem_wr_en` during its decision cycle. A refused write never raises it.
- R9: An allowed read raises `mem_rd_en`, and `dec_rdata` then equals `mem_rdata`. A refused read leaves `mem_rd_en` low and drives `dec_rdata` to 0xFFFFFFFF.
- R10: `rst_req` rises in the same cycle as the decision of the first refused transaction. It stays high until `rst_n` is asserted.
- R11: A write to a low register with bit 31 set stores that write's address field and locks the region. From then until reset, writes to any of the region's four registers are ignored, reads still return its contents, and other regions remain writable.
- R12: A transaction is accepted on a clock where `txn_valid` and `txn_ready` are both high, and its decision is presented from the next clock. `txn_ready` equals `!dec_valid || dec_ready`. While `dec_valid` is high and `dec_ready` is low, the decision and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| txn_valid | input | 1 | Transaction present |
| txn_ready | output | 1 | Filter can accept a transaction |
| txn_addr | input | 32 | Physical byte address |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_agent | input | 32 | One-hot requesting-agent identifier |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Downstream takes the decision |
| dec_allow | output | 1 | 1 = transaction allowed |
| dec_write | output | 1 | Direction of the decided transaction |
| dec_addr | output | 32 | Address of the decided transaction |
| mem_wr_en | output | 1 | Allowed write forwarded to memory |
| mem_rd_en | output | 1 | Allowed read forwarded to memory |
| mem_rdata | input | 32 | Read data from memory |
| dec_rdata | output | 32 | Read data to requester (all-ones when refused) |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The hardest situation to reach from the ports is an address that sits exactly on a block edge of one region while a second, overlapping region gives a different verdict for the same agent. Reaching it requires several regions programmed with shared edges and opposing masks. The stimulus programs six regions: one starting at address zero with a restricted mask, two overlapping ranges, a single-block region, one ending at the top of the address space, and a wide one. It then sweeps, in both directions, each of the fourteen agent codes (including none) across the byte before, at, at the last byte of and after every region edge. The lock freeze and the ready back-pressure are driven directly, and a second reset checks that both the lock and the reset request clear.

// File: rtl/memguard_pkg.sv
package memguard_pkg;

    localparam int WORD_W    = 32;
    localparam int BLK_W     = 22;      // physical address bits 31:10
    localparam int BLK_SHIFT = 10;      // 1 KiB granule
    localparam int FIELD_LSB = 2;       // field position inside address registers
    localparam int LOCK_BIT  = 31;
    localparam int SNOOP_BIT = 30;

    localparam logic [WORD_W-1:0] RD_OPEN = 32'hBFFF_FFFF;
    localparam logic [WORD_W-1:0] WR_OPEN = 32'hFFFF_FFFF;

    typedef struct packed {
        logic              lock;
        logic [BLK_W-1:0]  lo;
        logic [BLK_W-1:0]  hi;
        logic [WORD_W-1:0] rmask;
        logic [WORD_W-1:0] wmask;
    } region_t;

    function automatic logic region_is_off(input region_t r);
        return (r.lo == '0) && (r.hi == '0) &&
               (r.rmask == RD_OPEN) && (r.wmask == WR_OPEN);
    endfunction

    function automatic region_t region_reset_value();
        region_t r;
        r.lock  = 1'b0;
        r.lo    = '0;
        r.hi    = '0;
        r.rmask = RD_OPEN;
        r.wmask = WR_OPEN;
        return r;
    endfunction

endpackage

// File: rtl/memguard_regfile.sv
module memguard_regfile
    import memguard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int REG_BASE    = 64,
    parameter int REG_AW      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata,
    output region_t [NUM_REGIONS-1:0]     regions_o
);

    localparam int SPAN  = 4 * NUM_REGIONS;
    localparam int LIMIT = REG_BASE + SPAN;
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    typedef struct packed {
        region_t [NUM_REGIONS-1:0] rg;
    } state_t;

    state_t st_d, st_q;

    logic              in_range;
    logic [REG_AW-1:0] offset;
    logic [IDX_W-1:0]  sel;
    logic [1:0]        word;

    always_comb begin
        in_range = (int'(reg_addr) >= REG_BASE) && (int'(reg_addr) < LIMIT);
        offset   = reg_addr - REG_AW'(REG_BASE);
        sel      = offset[IDX_W+1:2];
        word     = offset[1:0];
    end

    // next-state
    always_comb begin
        st_d = st_q;
        if (reg_we && in_range && !st_q.rg[sel].lock) begin
            unique case (word)
                2'd0: begin
                    st_d.rg[sel].lo   = reg_wdata[FIELD_LSB +: BLK_W];
                    st_d.rg[sel].lock = reg_wdata[LOCK_BIT];
                end
                2'd1: st_d.rg[sel].hi = reg_wdata[FIELD_LSB +: BLK_W];
                2'd2: begin
                    st_d.rg[sel].rmask            = reg_wdata;
                    st_d.rg[sel].rmask[SNOOP_BIT] = 1'b0;
                end
                default: st_d.rg[sel].wmask = reg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                st_q.rg[i] <= region_reset_value();
            end
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (in_range) begin
            unique case (word)
                2'd0: begin
                    reg_rdata[FIELD_LSB +: BLK_W] = st_q.rg[sel].lo;
                    reg_rdata[LOCK_BIT]           = st_q.rg[sel].lock;
                end
                2'd1: reg_rdata[FIELD_LSB +: BLK_W] = st_q.rg[sel].hi;
                2'd2: reg_rdata = st_q.rg[sel].rmask;
                default: reg_rdata = st_q.rg[sel].wmask;
            endcase
        end
    end

    assign regions_o = st_q.rg;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lock_chk
        AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.rg[g].lock |=> $stable(st_q.rg[g]))
            else $error("locked region %0d changed", g); // R11
        AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.rg[g].lock |=> st_q.rg[g].lock)
            else $error("lock of region %0d cleared", g); // R11
    end

endmodule

// File: rtl/memguard_region_check.sv
module memguard_region_check
    import memguard_pkg::*;
(
    input  region_t           region_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic              is_write_i,
    input  logic [WORD_W-1:0] agent_i,
    output logic              hit_o,
    output logic              block_o
);

    logic              enabled;
    logic [WORD_W-1:0] mask;

    always_comb begin
        enabled = !region_is_off(region_i);
        hit_o   = enabled && (blk_i >= region_i.lo) && (blk_i <= region_i.hi);
        if (is_write_i) begin
            mask = region_i.wmask;
        end else begin
            // the snoop agent never reads, so its read bit cannot refuse
            mask            = region_i.rmask;
            mask[SNOOP_BIT] = 1'b1;
        end
        block_o = hit_o && ((agent_i & ~mask) != '0);
    end

endmodule

// File: rtl/memguard_filter.sv
module memguard_filter
    import memguard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int REG_BASE    = 64,
    parameter int REG_AW      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              txn_valid,
    output logic              txn_ready,
    input  logic [31:0]       txn_addr,
    input  logic              txn_write,
    input  logic [31:0]       txn_agent,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic              dec_allow,
    output logic              dec_write,
    output logic [31:0]       dec_addr,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       dec_rdata,
    output logic              rst_req
);

    typedef struct packed {
        logic              valid;
        logic              allow;
        logic              write;
        logic [WORD_W-1:0] addr;
        logic              rreq;
    } stage_t;

    region_t [NUM_REGIONS-1:0] regions;
    logic    [NUM_REGIONS-1:0] hit_vec;
    logic    [NUM_REGIONS-1:0] block_vec;
    logic    [BLK_W-1:0]       txn_blk;
    logic                      any_block;
    logic                      accept;

    stage_t st_d, st_q;

    memguard_regfile #(
        .NUM_REGIONS (NUM_REGIONS),
        .REG_BASE    (REG_BASE),
        .REG_AW      (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .regions_o (regions)
    );

    assign txn_blk = txn_addr[BLK_SHIFT +: BLK_W];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        memguard_region_check u_chk (
            .region_i   (regions[g]),
            .blk_i      (txn_blk),
            .is_write_i (txn_write),
            .agent_i    (txn_agent),
            .hit_o      (hit_vec[g]),
            .block_o    (block_vec[g])
        );
    end

    assign any_block = |block_vec;
    assign txn_ready = !st_q.valid || dec_ready;
    assign accept    = txn_valid && txn_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && dec_ready) begin
            st_d.valid = 1'b0;
        end
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.allow = !any_block;
            st_d.write = txn_write;
            st_d.addr  = txn_addr;
            if (any_block) begin
                st_d.rreq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid = st_q.valid;
    assign dec_allow = st_q.allow;
    assign dec_write = st_q.write;
    assign dec_addr  = st_q.addr;
    assign rst_req   = st_q.rreq;
    assign mem_wr_en = st_q.valid && st_q.allow && st_q.write;
    assign mem_rd_en = st_q.valid && st_q.allow && !st_q.write;
    assign dec_rdata = (st_q.valid && !st_q.write && !st_q.allow) ? '1 : mem_rdata;

    AST_VIOL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_allow) |-> rst_req)
        else $error("refused transaction without reset request"); // R10
    AST_RST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req)
        else $error("reset request dropped"); // R10
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=>
            (dec_valid && $stable(dec_addr) && $stable(dec_allow) && $stable(dec_write)))
        else $error("decision changed under back-pressure"); // R12
    AST_BLOCK_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_allow) |-> (!mem_wr_en && !mem_rd_en))
        else $error("refused transaction reached memory"); // R8
    AST_BLOCK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_write && !mem_rd_en) |-> (dec_rdata == '1))
        else $error("refused read returned memory data"); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr_en, mem_rd_en}))
        else $error("both memory strobes high"); // R8

endmodule

// File: tb/memguard_filter_tb.sv
module memguard_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        txn_valid;
    logic        txn_ready;
    logic [31:0] txn_addr;
    logic        txn_write;
    logic [31:0] txn_agent;
    logic        dec_valid;
    logic        dec_ready;
    logic        dec_allow;
    logic        dec_write;
    logic [31:0] dec_addr;
    logic        mem_wr_en;
    logic        mem_rd_en;
    logic [31:0] mem_rdata;
    logic [31:0] dec_rdata;
    logic        rst_req;

    always #5 clk = ~clk;

    memguard_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_write(txn_write), .txn_agent(txn_agent),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_allow(dec_allow),
        .dec_write(dec_write), .dec_addr(dec_addr),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .dec_rdata(dec_rdata), .rst_req(rst_req)
    );

    int total = 0;
    int bad   = 0;

    // bench-side model of the programmed regions
    logic [21:0] m_lo [8];
    logic [21:0] m_hi [8];
    logic [31:0] m_rm [8];
    logic [31:0] m_wm [8];
    logic        m_lk [8];
    logic        m_rreq;

    int agbits [13] = '{0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 29, 30, 31};

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_lo[i] = '0; m_hi[i] = '0;
            m_rm[i] = 32'hBFFF_FFFF; m_wm[i] = 32'hFFFF_FFFF;
            m_lk[i] = 1'b0;
        end
        m_rreq = 1'b0;
    endtask

    function automatic logic [31:0] exp_read(input int a);
        int n, w;
        if (a < 32'h40 || a >= 32'h60) return 32'h0;
        n = (a - 32'h40) / 4;
        w = (a - 32'h40) % 4;
        case (w)
            0: return {m_lk[n], 7'b0, m_lo[n], 2'b0};
            1: return {8'b0, m_hi[n], 2'b0};
            2: return m_rm[n];
            default: return m_wm[n];
        endcase
    endfunction

    function automatic logic exp_allow(input logic [31:0] a, input logic wr,
                                       input logic [31:0] ag);
        logic [21:0] blk;
        logic [31:0] mask;
        logic        off;
        blk = a[31:10];
        for (int i = 0; i < 8; i++) begin
            off = (m_lo[i] == 0) && (m_hi[i] == 0) &&
                  (m_rm[i] == 32'hBFFF_FFFF) && (m_wm[i] == 32'hFFFF_FFFF);
            if (!off && blk >= m_lo[i] && blk <= m_hi[i]) begin
                mask = wr ? m_wm[i] : (m_rm[i] | 32'h4000_0000);
                if ((ag & ~mask) != 0) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic reg_wr(input int a, input logic [31:0] d);
        int n, w;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a[7:0]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= 32'h40 && a < 32'h60) begin
            n = (a - 32'h40) / 4;
            w = (a - 32'h40) % 4;
            if (!m_lk[n]) begin
                case (w)
                    0: begin m_lo[n] = d[23:2]; m_lk[n] = d[31]; end
                    1: m_hi[n] = d[23:2];
                    2: m_rm[n] = d & 32'hBFFF_FFFF;
                    default: m_wm[n] = d;
                endcase
            end
        end
    endtask

    task automatic reg_chk(input int a, input string tag);
        @(negedge clk);
        reg_addr = a[7:0];
        #1;
        check(tag, $sformatf("readback @%02h", a), reg_rdata, exp_read(a));
    endtask

    task automatic set_region(input int n, input logic [21:0] lo, input logic [21:0] hi,
                              input logic [31:0] rm, input logic [31:0] wm);
        reg_wr(32'h40 + 4*n, {8'b0, lo, 2'b0});
        reg_wr(32'h41 + 4*n, {8'b0, hi, 2'b0});
        reg_wr(32'h42 + 4*n, rm);
        reg_wr(32'h43 + 4*n, wm);
    endtask

    task automatic run_txn(input logic [31:0] a, input logic wr, input logic [31:0] ag,
                           input string tag);
        logic ea;
        @(negedge clk);
        check("R12", "txn_ready before accept", {31'b0, txn_ready}, 32'h1);
        txn_valid = 1'b1; txn_addr = a; txn_write = wr; txn_agent = ag;
        dec_ready = 1'b1; mem_rdata = a ^ 32'h1357_9BDF;
        @(posedge clk);
        @(negedge clk);
        txn_valid = 1'b0;
        ea = exp_allow(a, wr, ag);
        if (!ea) m_rreq = 1'b1;
        check("R12", "dec_valid one clock after accept", {31'b0, dec_valid}, 32'h1);
        check(tag, $sformatf("allow a=%h wr=%0b ag=%h", a, wr, ag),
              {31'b0, dec_allow}, {31'b0, ea});
        check("R8", "mem_wr_en", {31'b0, mem_wr_en}, {31'b0, ea && wr});
        check("R9", "mem_rd_en", {31'b0, mem_rd_en}, {31'b0, ea && !wr});
        if (!wr) check("R9", "dec_rdata", dec_rdata, ea ? (a ^ 32'h1357_9BDF) : 32'hFFFF_FFFF);
        check("R10", "rst_req", {31'b0, rst_req}, {31'b0, m_rreq});
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] ag;
        longint      pts [4];
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        txn_valid = 1'b0; txn_addr = '0; txn_write = 1'b0; txn_agent = '0;
        dec_ready = 1'b1; mem_rdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int a = 32'h40; a < 32'h60; a++) reg_chk(a, "R1");
        check("R1", "rst_req after reset", {31'b0, rst_req}, 32'h0);
        check("R1", "dec_valid after reset", {31'b0, dec_valid}, 32'h0);
        run_txn(32'h0000_0000, 1'b1, 32'h1, "R1");
        run_txn(32'hFFFF_FFFC, 1'b0, 32'h8000_0000, "R1");

        // R2: reserved bits, out-of-range words
        reg_wr(32'h59, 32'hFFFF_FFFF);
        reg_chk(32'h59, "R2");
        reg_wr(32'h59, 32'h0);
        reg_wr(32'h3F, 32'hFFFF_FFFF);
        reg_wr(32'h60, 32'hFFFF_FFFF);
        reg_chk(32'h3F, "R2");
        reg_chk(32'h60, "R2");
        reg_chk(32'h10, "R2");

        // program regions: zero-based restricted, overlap pair, single block,
        // top of space, wide range
        set_region(0, 22'h0,      22'h0,      32'h0000_0001, 32'h0000_0001); // R4
        set_region(1, 22'h100,    22'h1FF,    32'h0000_0F03, 32'h0000_0003); // R7
        set_region(2, 22'h180,    22'h2FF,    32'hFFFF_FFFF, 32'h0000_0001); // R7, R6
        set_region(3, 22'h400,    22'h400,    32'h2000_0000, 32'h4000_0001);
        set_region(4, 22'h3FFF00, 22'h3FFFFF, 32'h8000_F000, 32'h8000_0000);
        set_region(7, 22'h1000,   22'h1800,   32'h0000_FF00, 32'h0000_FF00);
        for (int a = 32'h40; a < 32'h60; a++) reg_chk(a, "R2");

        // R11: lock region 3 with the address rewritten in the same word
        reg_wr(32'h4C, 32'h8000_0000 | {8'b0, 22'h400, 2'b0});
        reg_wr(32'h4C, 32'h0);
        reg_wr(32'h4D, 32'h0);
        reg_wr(32'h4E, 32'hFFFF_FFFF);
        reg_wr(32'h4F, 32'hFFFF_FFFF);
        for (int a = 32'h4C; a < 32'h50; a++) reg_chk(a, "R11");
        check("R11", "lock bit readback", {31'b0, exp_read(32'h4C) >> 31}, 32'h1);
        reg_wr(32'h56, 32'h0000_0100);
        reg_chk(32'h56, "R11");
        reg_wr(32'h56, 32'hBFFF_FFFF);
        reg_chk(32'h56, "R11");
        run_txn(32'h0010_0000, 1'b1, 32'h1, "R11");

        // sweep edges x agents x direction
        for (int r = 0; r < 8; r++) begin
            pts[0] = longint'(m_lo[r]) * 1024 - 1;
            pts[1] = longint'(m_lo[r]) * 1024;
            pts[2] = longint'(m_hi[r]) * 1024 + 1023;
            pts[3] = longint'(m_hi[r]) * 1024 + 1024;
            for (int p = 0; p < 4; p++) begin
                if (pts[p] < 0 || pts[p] > 64'hFFFF_FFFF) continue;
                for (int k = -1; k < 13; k++) begin
                    ag = (k < 0) ? 32'h0 : (32'h1 << agbits[k]);
                    for (int d = 0; d < 2; d++) begin
                        run_txn(pts[p][31:0], d[0],
                                ag, (r == 1 || r == 2) ? "R7" :
                                    (r == 0) ? "R4" :
                                    (p == 3) ? "R3" :
                                    (agbits[(k < 0) ? 0 : k] == 30) ? "R6" : "R5");
                    end
                end
            end
        end

        // R12: back-pressure
        @(negedge clk);
        dec_ready = 1'b0;
        txn_valid = 1'b1; txn_addr = 32'h0800_0000; txn_write = 1'b0; txn_agent = 32'h1;
        @(posedge clk);
        @(negedge clk);
        txn_addr = 32'h0800_0400;
        check("R12", "txn_ready while stalled", {31'b0, txn_ready}, 32'h0);
        check("R12", "dec_valid while stalled", {31'b0, dec_valid}, 32'h1);
        @(negedge clk);
        check("R12", "dec_addr held", dec_addr, 32'h0800_0000);
        check("R12", "dec_valid held", {31'b0, dec_valid}, 32'h1);
        dec_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        txn_valid = 1'b0;
        check("R12", "next txn replaces drained decision", dec_addr, 32'h0800_0400);
        check("R12", "dec_allow of replacing txn", {31'b0, dec_allow}, 32'h1);
        @(negedge clk);
        check("R12", "dec_valid drains", {31'b0, dec_valid}, 32'h0);

        // second reset clears lock and reset request
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        model_reset();
        check("R10", "rst_req cleared by reset", {31'b0, rst_req}, 32'h0);
        for (int a = 32'h4C; a < 32'h50; a++) reg_chk(a, "R1");
        reg_wr(32'h4F, 32'h0000_0001);
        reg_chk(32'h4F, "R11");

        finish_run();
    end

endmodule